// File: doc/BRIEF.md
# Dual-lane SECDED read checker

This block sits on the read path of a memory array whose locations are 144 bits wide. Each location carries a 128-bit data word split into two independent 64-bit lanes, and each lane has its own 8 check bits. On every read request the block decodes both lanes at the same time with a Hsiao single-error-correct, double-error-detect code. It returns the corrected word one cycle later and records per-lane correction and detection flags in a small status register.

The first error seen while all flags are clear captures the 16-byte-aligned location address. After that, the status register stays frozen until software has cleared every flag. Correction events drive an interrupt gated by an enable input. Detection events drive a non-maskable interrupt. Erased locations (every bit one) decode as clean, and one flipped bit in such a lane is still corrected.

A one-entry read buffer keeps the last fetched word. A re-read of that location returns the buffered word and raises no new flag. A write or erase to the buffered location invalidates it.

Top module: `dlane_ecc_checker`

## Requirements
- R1: `mem_word` layout: lane 0 data at bits 63:0, lane 1 data at 127:64, lane 0 check bits at 135:128, lane 1 check bits at 143:136. A request sampled at a clock edge yields `rd_valid`=1 and the result on `rd_data` after that same edge; with no request, `rd_valid` is 0. After reset, flags, interrupts and `rd_valid` are 0.
- R2: Code: data bit i of a lane has column i of a table listing all 8-bit weight-3 values in ascending order, followed by the eight smallest weight-5 values. Check bit j has the unit column 1<<j. The check byte is the XOR of the columns of the set data bits. A single flipped bit in a lane (data or check) is corrected. It sets `err_flags[0]` for lane 0 and `err_flags[1]` for lane 1, and both may be set by one read.
- R3: Two flipped bits in a lane are reported uncorrectable. This sets `err_flags[2]` for lane 0 and `err_flags[3]` for lane 1, and both may be set by one read.
- R4: `irq_corr` is 1 exactly when `ie_corr` is 1 and `err_flags[0]` or `err_flags[1]` is set. `nmi_det` is 1 exactly when `err_flags[2]` or `err_flags[3]` is set.
- R5: When errors are captured, `err_addr` takes `rd_addr` with its four low bits forced to zero.
- R6: While any flag is set, a new error changes neither the flags nor `err_addr`. Capture resumes only once all four flags are zero.
- R7: A lane whose 64 data bits and 8 check bits are all one decodes clean as all-ones data. If exactly one of those 72 bits is zero, the lane returns all-ones data and sets its correction flag.
- R8: A request whose `rd_addr[20:4]` matches the buffered location returns the buffered word, ignores `mem_word`, and sets no flag, even if the flags were cleared since the original read.
- R9: `wr_inv` with `wr_addr[20:4]` equal to the buffered location invalidates the buffer. A write elsewhere leaves the buffer intact.
- R10: Writing one to a bit of `flag_clr` clears that flag. A capture in the same cycle as a clear wins, so its flags end up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Read request, one cycle per read |
| rd_addr | input | 21 | Byte address of the read |
| mem_word | input | 144 | Raw stored location, valid with `rd_req` |
| wr_inv | input | 1 | Write or erase to `wr_addr` happened |
| wr_addr | input | 21 | Address of that write or erase |
| ie_corr | input | 1 | Correction interrupt enable |
| flag_clr | input | 4 | Write-one-to-clear mask for `err_flags` |
| rd_valid | output | 1 | `rd_data` holds a result |
| rd_data | output | 128 | Corrected or buffered data |
| err_flags | output | 4 | {det hi, det lo, corr hi, corr lo} |
| err_addr | output | 21 | Captured location address |
| irq_corr | output | 1 | Maskable correction interrupt |
| nmi_det | output | 1 | Non-maskable detection interrupt |

## Verification
The assertions assume that `flag_clr` is pulsed for a single cycle and that `rd_req` comes with a stable `mem_word` in the same cycle. They also assume that no lane is driven with three or more flipped bits, because the code gives no guarantee there. The bench drives every input on the falling edge. It pulses clears only between reads, except in the one priority case. It never injects more than two flipped bits per lane, and it picks a fresh block address for each read that must miss the buffer.

// File: rtl/dle_pkg.sv
package dle_pkg;
  localparam int LANE_W = 64;
  localparam int CHK_W  = 8;
  localparam int COL_TBL_W = LANE_W * CHK_W;

  // Odd-weight columns: weight-3 ascending, then weight-5 ascending.
  function automatic logic [COL_TBL_W-1:0] build_cols();
    logic [COL_TBL_W-1:0] t;
    logic [7:0] vb;
    int k;
    t = '0;
    k = 0;
    for (int w = 3; w <= 5; w += 2) begin
      for (int v = 1; v < 256; v++) begin
        vb = 8'(v);
        if ($countones(vb) == w && k < LANE_W) begin
          t[k*CHK_W +: CHK_W] = vb;
          k++;
        end
      end
    end
    return t;
  endfunction

  function automatic logic [CHK_W-1:0] hsiao_enc(input logic [LANE_W-1:0] d,
                                                 input logic [COL_TBL_W-1:0] cols);
    logic [CHK_W-1:0] c;
    c = '0;
    for (int i = 0; i < LANE_W; i++)
      if (d[i]) c ^= cols[i*CHK_W +: CHK_W];
    return c;
  endfunction
endpackage

// File: rtl/dle_lane_dec.sv
module dle_lane_dec
  import dle_pkg::*;
(
  input  logic [LANE_W-1:0] din,
  input  logic [CHK_W-1:0]  cin,
  output logic [LANE_W-1:0] dout,
  output logic              corr,
  output logic              det
);
  localparam logic [COL_TBL_W-1:0] COLS = build_cols();

  logic [CHK_W-1:0]        syn;
  logic [LANE_W+CHK_W-1:0] zeros_in;
  logic [LANE_W-1:0]       flip;
  logic                    near_erased;

  always_comb begin
    zeros_in    = ~{cin, din};
    near_erased = ($countones(zeros_in) <= 1);
    syn         = cin ^ hsiao_enc(din, COLS);
    flip        = '0;
    for (int i = 0; i < LANE_W; i++)
      if (COLS[i*CHK_W +: CHK_W] == syn) flip[i] = 1'b1;
  end

  always_comb begin
    dout = din;
    corr = 1'b0;
    det  = 1'b0;
    if (near_erased) begin
      dout = '1;
      corr = (zeros_in != '0);
    end else if (syn != '0) begin
      if (!$countones(syn)[0]) begin
        det = 1'b1;
      end else if ($countones(syn) == 1) begin
        corr = 1'b1;
      end else if (flip != '0) begin
        dout = din ^ flip;
        corr = 1'b1;
      end else begin
        det = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dle_rd_buf.sv
module dle_rd_buf #(
  parameter int TAG_W = 17,
  parameter int DW    = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] look_tag,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [DW-1:0]    fill_data,
  input  logic             inv_en,
  input  logic [TAG_W-1:0] inv_tag,
  output logic             hit,
  output logic [DW-1:0]    buf_data
);
  logic             vld;
  logic [TAG_W-1:0] tag;
  logic [TAG_W-1:0] tag_nxt;
  logic             kill;

  assign hit     = vld && (tag == look_tag);
  assign tag_nxt = fill_en ? fill_tag : tag;
  assign kill    = inv_en && (inv_tag == tag_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld      <= 1'b0;
      tag      <= '0;
      buf_data <= '0;
    end else begin
      if (fill_en) begin
        tag      <= fill_tag;
        buf_data <= fill_data;
      end
      vld <= (fill_en || vld) && !kill;
    end
  end
endmodule

// File: rtl/dle_err_status.sv
module dle_err_status #(
  parameter int NF     = 4,
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NF-1:0]     ev,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [NF-1:0]     clr,
  output logic [NF-1:0]     flags,
  output logic [ADDR_W-1:0] addr
);
  logic          cap_ok;
  logic [NF-1:0] set_v;

  assign cap_ok = (flags == '0);
  assign set_v  = cap_ok ? ev : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      addr  <= '0;
    end else begin
      flags <= (flags & ~clr) | set_v;
      if (set_v != '0) addr <= ev_addr;
    end
  end
endmodule

// File: rtl/dlane_ecc_checker.sv
module dlane_ecc_checker
  import dle_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int BLK_LSB = 4,
  parameter int LANES   = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rd_req,
  input  logic [ADDR_W-1:0]                rd_addr,
  input  logic [LANES*(LANE_W+CHK_W)-1:0]  mem_word,
  input  logic                             wr_inv,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic                             ie_corr,
  input  logic [2*LANES-1:0]               flag_clr,
  output logic                             rd_valid,
  output logic [LANES*LANE_W-1:0]          rd_data,
  output logic [2*LANES-1:0]               err_flags,
  output logic [ADDR_W-1:0]                err_addr,
  output logic                             irq_corr,
  output logic                             nmi_det
);
  localparam int DW    = LANES * LANE_W;
  localparam int TAG_W = ADDR_W - BLK_LSB;
  localparam int NF    = 2 * LANES;

  logic [DW-1:0]     dec_data;
  logic [LANES-1:0]  lane_corr;
  logic [LANES-1:0]  lane_det;
  logic              buf_hit;
  logic [DW-1:0]     buf_data;
  logic              miss_rd;
  logic [NF-1:0]     err_ev;
  logic [ADDR_W-1:0] blk_addr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dle_lane_dec u_dec (
      .din  (mem_word[g*LANE_W +: LANE_W]),
      .cin  (mem_word[DW + g*CHK_W +: CHK_W]),
      .dout (dec_data[g*LANE_W +: LANE_W]),
      .corr (lane_corr[g]),
      .det  (lane_det[g])
    );
  end

  assign miss_rd  = rd_req && !buf_hit;
  assign err_ev   = miss_rd ? {lane_det, lane_corr} : '0;
  assign blk_addr = {rd_addr[ADDR_W-1:BLK_LSB], {BLK_LSB{1'b0}}};

  dle_rd_buf #(.TAG_W(TAG_W), .DW(DW)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_tag  (rd_addr[ADDR_W-1:BLK_LSB]),
    .fill_en   (miss_rd),
    .fill_tag  (rd_addr[ADDR_W-1:BLK_LSB]),
    .fill_data (dec_data),
    .inv_en    (wr_inv),
    .inv_tag   (wr_addr[ADDR_W-1:BLK_LSB]),
    .hit       (buf_hit),
    .buf_data  (buf_data)
  );

  dle_err_status #(.NF(NF), .ADDR_W(ADDR_W)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (err_ev),
    .ev_addr (blk_addr),
    .clr     (flag_clr),
    .flags   (err_flags),
    .addr    (err_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= buf_hit ? buf_data : dec_data;
    end
  end

  assign irq_corr = ie_corr && (err_flags[LANES-1:0] != '0);
  assign nmi_det  = (err_flags[NF-1:LANES] != '0);
endmodule

// File: rtl/dle_chk.sv
module dle_chk #(
  parameter int NF     = 4,
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic              buf_hit,
  input logic              rd_valid,
  input logic [NF-1:0]     err_flags,
  input logic [NF-1:0]     flag_clr,
  input logic [ADDR_W-1:0] err_addr,
  input logic              nmi_det
);
  // R1
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  // R1
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  // R6
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags != '0 && flag_clr == '0) |=> ($stable(err_flags) && $stable(err_addr)));
  // R8
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && buf_hit && err_flags == '0) |=> (err_flags == '0));
  // R4
  nmi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_det) |-> $past(rd_req && !buf_hit));
endmodule

bind dlane_ecc_checker dle_chk #(.NF(2*LANES), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_req    (rd_req),
  .buf_hit   (buf_hit),
  .rd_valid  (rd_valid),
  .err_flags (err_flags),
  .flag_clr  (flag_clr),
  .err_addr  (err_addr),
  .nmi_det   (nmi_det)
);

// File: tb/dlane_ecc_checker_tb.sv
module dlane_ecc_checker_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rd_req = 1'b0;
  logic [20:0]  rd_addr = '0;
  logic [143:0] mem_word = '0;
  logic         wr_inv = 1'b0;
  logic [20:0]  wr_addr = '0;
  logic         ie_corr = 1'b0;
  logic [3:0]   flag_clr = '0;
  logic         rd_valid;
  logic [127:0] rd_data;
  logic [3:0]   err_flags;
  logic [20:0]  err_addr;
  logic         irq_corr;
  logic         nmi_det;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] tcol [64];

  localparam logic [127:0] D0 = 128'h0123456789abcdef_fedcba9876543210;
  localparam logic [127:0] D1 = 128'hdeadbeefcafef00d_13579bdf2468ace0;
  localparam logic [127:0] D2 = 128'h55aa33cc0ff0a5a5_9e3779b97f4a7c15;

  always #2.5 clk = ~clk;

  dlane_ecc_checker u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] tenc(input logic [63:0] d);
    logic [7:0] c = '0;
    for (int i = 0; i < 64; i++) if (d[i]) c = c ^ tcol[i];
    return c;
  endfunction

  function automatic logic [143:0] mk(input logic [127:0] d);
    return {tenc(d[127:64]), tenc(d[63:0]), d};
  endfunction

  task automatic rd(input logic [20:0] a, input logic [143:0] w, input logic [3:0] clr = 4'h0);
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a; mem_word = w; flag_clr = clr;
    @(negedge clk);
    rd_req = 1'b0; flag_clr = 4'h0;
  endtask

  task automatic clear(input logic [3:0] m);
    @(negedge clk);
    flag_clr = m;
    @(negedge clk);
    flag_clr = 4'h0;
  endtask

  task automatic inval(input logic [20:0] a);
    @(negedge clk);
    wr_inv = 1'b1; wr_addr = a;
    @(negedge clk);
    wr_inv = 1'b0;
  endtask

  task automatic t_reset();
    chk(err_flags == 0, "R1 reset flags", 128'(err_flags), 0);
    chk(!irq_corr && !nmi_det, "R1 reset irq", 128'({irq_corr, nmi_det}), 0);
    chk(!rd_valid, "R1 reset valid", 128'(rd_valid), 0);
  endtask

  task automatic t_clean();
    rd(21'h00100, mk(D0));
    chk(rd_valid, "R1 valid", 128'(rd_valid), 1);
    chk(rd_data == D0, "R1 clean data", rd_data, D0);
    chk(err_flags == 0, "R1 clean flags", 128'(err_flags), 0);
    @(negedge clk);
    chk(!rd_valid, "R1 idle", 128'(rd_valid), 0);
  endtask

  task automatic t_single();
    rd(21'h00200, mk(D1) ^ (144'd1 << 5));
    chk(rd_data == D1, "R2 lo data", rd_data, D1);
    chk(err_flags == 4'b0001, "R2 lo flag", 128'(err_flags), 128'h1);
    chk(err_addr == 21'h00200, "R5 addr", 128'(err_addr), 128'h200);
    chk(!irq_corr, "R4 masked", 128'(irq_corr), 0);
    ie_corr = 1'b1;
    @(negedge clk);
    chk(irq_corr, "R4 enabled", 128'(irq_corr), 1);
    clear(4'b0001);
    chk(err_flags == 0, "R10 w1c", 128'(err_flags), 0);
    rd(21'h00317, mk(D1) ^ (144'd1 << 100) ^ (144'd1 << 130));
    chk(rd_data == D1, "R2 both data", rd_data, D1);
    chk(err_flags == 4'b0011, "R2 both flags", 128'(err_flags), 128'h3);
    chk(err_addr == 21'h00310, "R5 aligned", 128'(err_addr), 128'h310);
    clear(4'b1111);
  endtask

  task automatic t_double();
    rd(21'h00400, mk(D0) ^ (144'd3 << 1) ^ (144'd3 << 70));
    chk(err_flags == 4'b1100, "R3 det flags", 128'(err_flags), 128'hc);
    chk(nmi_det, "R4 nmi", 128'(nmi_det), 1);
    chk(!irq_corr, "R4 no corr irq", 128'(irq_corr), 0);
  endtask

  task automatic t_freeze();
    rd(21'h00500, mk(D2) ^ (144'd1 << 9));
    chk(rd_data == D2, "R2 corrected while frozen", rd_data, D2);
    chk(err_flags == 4'b1100, "R6 flags frozen", 128'(err_flags), 128'hc);
    chk(err_addr == 21'h00400, "R6 addr frozen", 128'(err_addr), 128'h400);
    clear(4'b0100);
    chk(err_flags == 4'b1000, "R10 partial clear", 128'(err_flags), 128'h8);
    rd(21'h00600, mk(D2) ^ (144'd1 << 140));
    chk(err_flags == 4'b1000 && err_addr == 21'h00400, "R6 still frozen",
        128'({err_flags, err_addr}), 128'({4'h8, 21'h00400}));
    clear(4'b1000);
    rd(21'h00700, mk(D2) ^ (144'd1 << 127));
    chk(err_flags == 4'b0010 && err_addr == 21'h00700, "R6 resumed",
        128'({err_flags, err_addr}), 128'({4'h2, 21'h00700}));
    clear(4'b1111);
  endtask

  task automatic t_erased();
    rd(21'h00800, '1);
    chk(rd_data == '1 && err_flags == 0, "R7 erased clean",
        128'({rd_data[3:0], err_flags}), 128'({4'hf, 4'h0}));
    rd(21'h00900, ~(144'd1 << 77));
    chk(rd_data == '1, "R7 erased data fix", rd_data, '1);
    chk(err_flags == 4'b0010, "R7 erased hi flag", 128'(err_flags), 128'h2);
    clear(4'b1111);
    rd(21'h00A00, ~(144'd1 << 129));
    chk(err_flags == 4'b0001 && rd_data == '1, "R7 erased check bit",
        128'(err_flags), 128'h1);
    clear(4'b1111);
  endtask

  task automatic t_buffer();
    rd(21'h00B00, mk(D1) ^ (144'd1 << 33));
    chk(err_flags == 4'b0001, "R8 first read", 128'(err_flags), 128'h1);
    clear(4'b1111);
    rd(21'h00B08, mk(D1) ^ (144'd1 << 33));
    chk(err_flags == 0 && rd_data == D1, "R8 hit no flag", 128'(err_flags), 0);
    rd(21'h00B00, mk(D0) ^ (144'd3 << 10));
    chk(rd_data == D1, "R8 hit ignores mem", rd_data, D1);
    chk(err_flags == 0, "R8 hit no det", 128'(err_flags), 0);
  endtask

  task automatic t_inval();
    inval(21'h00B04);
    rd(21'h00B00, mk(D1) ^ (144'd1 << 33));
    chk(err_flags == 4'b0001, "R9 invalidated", 128'(err_flags), 128'h1);
    clear(4'b1111);
    rd(21'h00C00, mk(D2));
    inval(21'h00D00);
    rd(21'h00C00, mk(D0) ^ (144'd3 << 10));
    chk(rd_data == D2 && err_flags == 0, "R9 other addr keeps", rd_data, D2);
  endtask

  task automatic t_prio();
    rd(21'h00E00, mk(D0) ^ (144'd1 << 40), 4'b1111);
    chk(err_flags == 4'b0001, "R10 set beats clear", 128'(err_flags), 128'h1);
    chk(err_addr == 21'h00E00, "R10 addr", 128'(err_addr), 128'he00);
  endtask

  initial begin
    int k = 0;
    for (int w = 3; w <= 5; w += 2)
      for (int v = 1; v < 256 && k < 64; v++)
        if ($countones(8'(v)) == w) begin tcol[k] = 8'(v); k++; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_single();
    t_double();
    t_freeze();
    t_erased();
    t_buffer();
    t_inval();
    t_prio();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule